// File: doc/BRIEF.md
# DSI Command Packet Sequencer

This block drains a short, software-programmed list of display-link commands onto a byte-wide high-speed transmit interface. Eight register slots each hold one command. A start pulse sends slots 0 through a programmed last index in order. Each command goes out as a four-byte header: an identifier byte, two field bytes and a Hamming ECC byte. A long command then streams its payload from a shared 256-byte RAM and closes with a 16-bit CRC.

After the last command the block can append an end-of-transmission packet and can raise a bus-turnaround request. During the turnaround, bytes returned by the peripheral are written into the same RAM from a programmable base offset. A counter reports how many bytes were stored, and software reads them back through a separate RAM read port. A turnaround-only start skips the command list entirely. A pause input holds the sequencer at each command boundary, so that an outer scheduler can slot video frames in between commands.

Top module: `dsi_cmd_sequencer`

## Requirements
- R1: A start pulse sends the commands in slots 0 through `last_idx` (0 to 7) in ascending slot order; slots above `last_idx` are not sent.
- R2: Each packet begins with byte `{vc[1:0], dt[5:0]}`, followed by the slot's 16-bit field, low byte first. For a short packet the field is the data; for a long packet it is the payload length. `slot_long` = 1 marks a long packet.
- R3: The fourth header byte is the ECC. Its bits 5:0 are the 6-bit Hamming parity over the 24 header bits (byte 0 in bits 7:0), and bits 7:6 are zero.
- R4: Long payloads are read from the payload RAM back to back, in command order, starting at address 0. A long packet of length 0 sends no payload bytes.
- R5: A long packet ends with a CRC over its payload, sent low byte first. The CRC uses polynomial x^16+x^12+x^5+1, initial value 0xFFFF, and processes bits LSB first, so an empty payload gives 0xFFFF.
- R6: `tx_en` rises on an accepted start. `done` pulses for one cycle when the sequence finishes, and `tx_en` is low on the following cycle. After reset both are 0, as are `tx_valid` and `ta_req`.
- R7: With `eot_en` = 1, the bytes 0x08, 0x0F, 0x0F, 0x01 follow the last command. With `eot_en` = 0 they are absent.
- R8: With `ta_en` = 1, `ta_req` rises only after the final packet byte is accepted. While `ta_req` is high, each `rx_valid` byte is written to RAM address `rx_base + n` (modulo 256), and `rx_end` finishes the sequence.
- R9: With `ta_only` = 1, a start sends no bytes and goes straight to the turnaround.
- R10: `rx_count` (0 to 256) is cleared by a start and counts the stored bytes. Once it reaches 256, further received bytes are neither stored nor counted.
- R11: A start pulse that arrives while `tx_en` is high is ignored.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_byte` and `tx_valid` hold.
- R13: While `seq_pause` is high, no command header is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_we | input | 1 | Write one command slot |
| slot_sel | input | 3 | Slot index to write |
| slot_dt | input | 6 | Data type for the slot |
| slot_vc | input | 2 | Virtual channel for the slot |
| slot_field | input | 16 | Short data or long length |
| slot_long | input | 1 | 1 = long packet |
| last_idx | input | 3 | Index of the last slot to send |
| ta_en | input | 1 | Turnaround after the last command |
| ta_only | input | 1 | Turnaround without commands |
| eot_en | input | 1 | Append end-of-transmission packet |
| rx_base | input | 8 | RAM offset for returned bytes |
| host_we | input | 1 | Host RAM write strobe |
| host_addr | input | 8 | Host RAM write address |
| host_wdata | input | 8 | Host RAM write data |
| rdbk_addr | input | 8 | Readback address |
| rdbk_data | output | 8 | Readback data |
| start | input | 1 | Start pulse |
| seq_pause | input | 1 | Hold at command boundary |
| tx_en | output | 1 | Sequence active, clears itself |
| done | output | 1 | One-cycle finish pulse |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Link accepts byte |
| tx_byte | output | 8 | Transmit byte |
| ta_req | output | 1 | Turnaround request |
| rx_valid | input | 1 | Returned byte valid |
| rx_byte | input | 8 | Returned byte |
| rx_end | input | 1 | Turnaround finished |
| rx_count | output | 9 | Stored returned bytes |

## Verification
The sequencer is tried with an all-short list and a mixed short/long list that includes a zero-length long packet. These tell apart header ordering, field byte order, payload address continuity across commands and the CRC seed. The mixed list is also replayed under random link backpressure, which shows that accepted bytes never skip or repeat. Separate runs switch the end-of-transmission packet on and off and apply a pause before the first header. The turnaround runs use a base offset that wraps past address 255 and an overlong reply that must saturate at 256. A second start issued mid-stream must leave exactly one sequence on the link.

// File: rtl/dsi_seq_pkg.sv
// Shared types for the DSI command sequencer.
package dsi_seq_pkg;

    // One programmed command slot.
    typedef struct packed {
        logic [5:0]  dt;
        logic [1:0]  vc;
        logic [15:0] field;
        logic        is_long;
    } slot_t;

    // Sequencer phases.
    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_PAY,
        S_CRC,
        S_EOT,
        S_TA,
        S_FIN
    } seq_state_t;

endpackage

// File: rtl/dsi_slot_bank.sv
// Register bank of command slots: one write port, one combinational read port.
// Assumes the write index is always below NSLOT.
module dsi_slot_bank
    import dsi_seq_pkg::*;
#(
    parameter int NSLOT = 8,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  slot_t         wdata,
    input  logic [SW-1:0] raddr,
    output slot_t         rdata
);
    slot_t slots [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // Hold slot g, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                     slots[g] <= '0;
            else if (we && waddr == SW'(g)) slots[g] <= wdata;
        end
    end

    assign rdata = slots[raddr];

endmodule

// File: rtl/dsi_hdr_ecc.sv
// Packet header ECC: 6 Hamming parity bits over 24 header bits, top 2 bits zero.
// Purely combinational.
module dsi_hdr_ecc (
    input  logic [23:0] hdr,
    output logic [7:0]  ecc
);
    localparam logic [23:0] M0 = 24'hF12CB7;
    localparam logic [23:0] M1 = 24'hF2555B;
    localparam logic [23:0] M2 = 24'h749A6D;
    localparam logic [23:0] M3 = 24'hB8E38E;
    localparam logic [23:0] M4 = 24'hDF03F0;
    localparam logic [23:0] M5 = 24'hEFFC00;

    // Reduce each parity mask over the header.
    always_comb begin
        ecc    = '0;
        ecc[0] = ^(hdr & M0);
        ecc[1] = ^(hdr & M1);
        ecc[2] = ^(hdr & M2);
        ecc[3] = ^(hdr & M3);
        ecc[4] = ^(hdr & M4);
        ecc[5] = ^(hdr & M5);
    end

endmodule

// File: rtl/dsi_crc16.sv
// Running payload CRC: poly x^16+x^12+x^5+1, seed 0xFFFF, bits LSB first.
// clr has priority over step.
module dsi_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // Seed on clear, fold one byte per step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= 16'hFFFF;
        else if (step)     crc <= crc_byte(crc, din);
    end

endmodule

// File: rtl/dsi_payload_ram.sv
// Shared payload / return-data RAM: one write port, two combinational read ports.
// Contents are not reset.
module dsi_payload_ram #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [7:0]    ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [7:0]    rb_data
);
    logic [7:0] mem [DEPTH];

    // Store one byte per write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

endmodule

// File: rtl/dsi_cmd_sequencer.sv
// Sends slots 0..last_idx as DSI packets over a valid/ready byte link.
// Optionally appends an end-of-transmission packet, then a turnaround that
// captures returned bytes into the payload RAM. Config inputs are assumed
// stable while tx_en is high.
module dsi_cmd_sequencer
    import dsi_seq_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int RAM_DEPTH = 256,
    localparam int SW = $clog2(NSLOT),
    localparam int AW = $clog2(RAM_DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_we,
    input  logic [SW-1:0] slot_sel,
    input  logic [5:0]    slot_dt,
    input  logic [1:0]    slot_vc,
    input  logic [15:0]   slot_field,
    input  logic          slot_long,
    input  logic [SW-1:0] last_idx,
    input  logic          ta_en,
    input  logic          ta_only,
    input  logic          eot_en,
    input  logic [AW-1:0] rx_base,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    input  logic [AW-1:0] rdbk_addr,
    output logic [7:0]    rdbk_data,
    input  logic          start,
    input  logic          seq_pause,
    output logic          tx_en,
    output logic          done,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_byte,
    output logic          ta_req,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          rx_end,
    output logic [CW-1:0] rx_count
);
    localparam logic [23:0]   EOT_HDR = 24'h0F0F08;
    localparam logic [CW-1:0] CNT_MAX = CW'(RAM_DEPTH);

    seq_state_t    state, post_cmd;
    logic [SW-1:0] cmd_idx;
    logic [1:0]    sub;
    logic [15:0]   remain;
    logic [AW-1:0] ram_ptr;
    slot_t         cur, wslot;
    logic [23:0]   hdr_word;
    logic [7:0]    ecc, pay_byte;
    logic [15:0]   crc;
    logic          fire, crc_clr, crc_step, rx_wr;

    assign wslot = '{dt: slot_dt, vc: slot_vc, field: slot_field, is_long: slot_long};

    dsi_slot_bank #(.NSLOT(NSLOT)) u_slots (
        .clk(clk), .rst_n(rst_n), .we(slot_we), .waddr(slot_sel),
        .wdata(wslot), .raddr(cmd_idx), .rdata(cur)
    );

    assign hdr_word = (state == S_EOT) ? EOT_HDR : {cur.field, cur.vc, cur.dt};

    dsi_hdr_ecc u_ecc (.hdr(hdr_word), .ecc(ecc));

    assign rx_wr = (state == S_TA) && rx_valid && (rx_count < CNT_MAX);

    dsi_payload_ram #(.DEPTH(RAM_DEPTH)) u_ram (
        .clk(clk), .we(rx_wr || host_we),
        .waddr(rx_wr ? rx_base + rx_count[AW-1:0] : host_addr),
        .wdata(rx_wr ? rx_byte : host_wdata),
        .ra_addr(ram_ptr), .ra_data(pay_byte),
        .rb_addr(rdbk_addr), .rb_data(rdbk_data)
    );

    assign crc_clr  = (state == S_HDR) && fire && (sub == 2'd3);
    assign crc_step = (state == S_PAY) && fire;

    dsi_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .step(crc_step),
        .din(pay_byte), .crc(crc)
    );

    // Pick the outgoing byte for the current phase.
    always_comb begin
        unique case (state)
            S_HDR, S_EOT: tx_byte = (sub == 2'd3) ? ecc : hdr_word[8*sub +: 8];
            S_PAY:        tx_byte = pay_byte;
            S_CRC:        tx_byte = sub[0] ? crc[15:8] : crc[7:0];
            default:      tx_byte = '0;
        endcase
    end

    assign tx_valid = (state inside {S_HDR, S_PAY, S_CRC, S_EOT})
                      && !(state == S_HDR && sub == 2'd0 && seq_pause);
    assign fire     = tx_valid && tx_ready;
    assign tx_en    = (state != S_IDLE);
    assign done     = (state == S_FIN);
    assign ta_req   = (state == S_TA);

    // Decide what follows the end of the current command.
    always_comb begin
        if (cmd_idx != last_idx) post_cmd = S_HDR;
        else if (eot_en)         post_cmd = S_EOT;
        else if (ta_en)          post_cmd = S_TA;
        else                     post_cmd = S_FIN;
    end

    // Main phase sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cmd_idx  <= '0;
            sub      <= '0;
            remain   <= '0;
            ram_ptr  <= '0;
            rx_count <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    cmd_idx  <= '0;
                    sub      <= '0;
                    ram_ptr  <= '0;
                    rx_count <= '0;
                    state    <= ta_only ? S_TA : S_HDR;
                end
                S_HDR: if (fire) begin
                    sub <= sub + 2'd1;
                    if (sub == 2'd3) begin
                        if (cur.is_long) begin
                            remain <= cur.field;
                            state  <= (cur.field == 16'd0) ? S_CRC : S_PAY;
                        end else begin
                            state <= post_cmd;
                            if (post_cmd == S_HDR) cmd_idx <= cmd_idx + 1'b1;
                        end
                    end
                end
                S_PAY: if (fire) begin
                    ram_ptr <= ram_ptr + 1'b1;
                    remain  <= remain - 16'd1;
                    if (remain == 16'd1) state <= S_CRC;
                end
                S_CRC: if (fire) begin
                    sub <= sub ^ 2'd1;
                    if (sub[0]) begin
                        sub   <= '0;
                        state <= post_cmd;
                        if (post_cmd == S_HDR) cmd_idx <= cmd_idx + 1'b1;
                    end
                end
                S_EOT: if (fire) begin
                    sub <= sub + 2'd1;
                    if (sub == 2'd3) state <= ta_en ? S_TA : S_FIN;
                end
                S_TA: begin
                    if (rx_wr)  rx_count <= rx_count + 1'b1;
                    if (rx_end) state <= S_FIN;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Assertions.
    p_hold_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
    p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !tx_en && !done);
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAY && tx_ready) |=> ram_ptr == $past(ram_ptr) + 1'b1);
    p_count_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CNT_MAX);
    p_rx_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_TA && !(state == S_IDLE && start)) |=> $stable(rx_count));

endmodule

// File: tb/dsi_cmd_sequencer_bench.sv
module dsi_cmd_sequencer_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic slot_we = 0, slot_long = 0;
    logic [2:0] slot_sel = 0, last_idx = 0;
    logic [5:0] slot_dt = 0;
    logic [1:0] slot_vc = 0;
    logic [15:0] slot_field = 0;
    logic ta_en = 0, ta_only = 0, eot_en = 0;
    logic [7:0] rx_base = 0, host_addr = 0, host_wdata = 0, rdbk_addr = 0, rdbk_data;
    logic host_we = 0, start = 0, seq_pause = 0;
    logic tx_en, done, tx_valid, ta_req;
    logic tx_ready = 1;
    logic [7:0] tx_byte;
    logic rx_valid = 0, rx_end = 0;
    logic [7:0] rx_byte = 0;
    logic [8:0] rx_count;

    int n_run = 0, n_fail = 0;
    logic [7:0] cap [1024];
    logic [7:0] expb [1024];
    logic [7:0] sh_mem [256];
    int cap_n = 0, exp_n = 0, valid_cycles = 0, done_cnt = 0, cap_at_ta = -1;
    bit ta_seen = 0, throttle = 0, finished = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsi_cmd_sequencer u_dsi_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .slot_we(slot_we), .slot_sel(slot_sel),
        .slot_dt(slot_dt), .slot_vc(slot_vc), .slot_field(slot_field), .slot_long(slot_long),
        .last_idx(last_idx), .ta_en(ta_en), .ta_only(ta_only), .eot_en(eot_en),
        .rx_base(rx_base), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .rdbk_addr(rdbk_addr), .rdbk_data(rdbk_data), .start(start), .seq_pause(seq_pause),
        .tx_en(tx_en), .done(done), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .ta_req(ta_req), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_end(rx_end),
        .rx_count(rx_count)
    );

    // Link ready: always on, or pseudo-random when throttling.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = throttle ? lfsr[0] : 1'b1;
    end

    // Monitor away from the active edge.
    always @(negedge clk) begin
        if (tx_valid && tx_ready && cap_n < 1024) begin cap[cap_n] = tx_byte; cap_n++; end
        if (tx_valid) valid_cycles++;
        if (done) done_cnt++;
        if (ta_req && !ta_seen) begin ta_seen = 1; cap_at_ta = cap_n; end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_ecc(input logic [23:0] d);
        logic [7:0] e = '0;
        e[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
        e[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
        e[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
        e[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
        e[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
        e[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
        return e;
    endfunction

    task automatic push(input logic [7:0] b);
        expb[exp_n] = b; exp_n++;
    endtask

    task automatic add_hdr(input logic [5:0] dt, input logic [1:0] vc, input logic [15:0] f);
        push({vc, dt}); push(f[7:0]); push(f[15:8]); push(ref_ecc({f, vc, dt}));
    endtask

    task automatic add_long(input logic [5:0] dt, input logic [1:0] vc, input int len, input int base);
        logic [15:0] c = 16'hFFFF;
        add_hdr(dt, vc, 16'(len));
        for (int i = 0; i < len; i++) begin
            logic [7:0] b = sh_mem[(base + i) % 256];
            push(b);
            for (int k = 0; k < 8; k++) c = (c[0] ^ b[k]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        push(c[7:0]); push(c[15:8]);
    endtask

    task automatic clear_cap();
        cap_n = 0; exp_n = 0; valid_cycles = 0; ta_seen = 0; cap_at_ta = -1;
    endtask

    task automatic prog_slot(input int i, input logic [5:0] dt, input logic [1:0] vc,
                             input logic [15:0] f, input bit lng);
        @(posedge clk); #1;
        slot_we = 1; slot_sel = 3'(i); slot_dt = dt; slot_vc = vc; slot_field = f; slot_long = lng;
        @(posedge clk); #1; slot_we = 0;
    endtask

    task automatic ram_write(input int a, input logic [7:0] d);
        @(posedge clk); #1;
        host_we = 1; host_addr = 8'(a); host_wdata = d; sh_mem[a] = d;
        @(posedge clk); #1; host_we = 0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1; start = 1;
        @(posedge clk); #1; start = 0;
    endtask

    task automatic wait_done(input string tag);
        int d0 = done_cnt;
        int t = 0;
        while (done_cnt == d0 && t < 20000) begin @(negedge clk); t++; end
        check(done_cnt != d0, {tag, " done seen"}, done_cnt - d0, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_stream(input string tag);
        int bad = -1;
        check(cap_n == exp_n, {tag, " byte count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (bad < 0 && cap[i] !== expb[i]) bad = i;
        if (bad >= 0) check(0, {tag, " stream byte"}, cap[bad], expb[bad]);
        else          check(1, {tag, " stream byte"}, 0, 0);
    endtask

    task automatic rx_send(input logic [7:0] v);
        @(posedge clk); #1; rx_valid = 1; rx_byte = v;
        @(posedge clk); #1; rx_valid = 0;
    endtask

    task automatic rx_finish();
        @(posedge clk); #1; rx_end = 1;
        @(posedge clk); #1; rx_end = 0;
    endtask

    task automatic read_ram(input int a, output logic [7:0] v);
        @(posedge clk); #1; rdbk_addr = 8'(a);
        @(negedge clk); v = rdbk_data;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(tx_en == 0 && done == 0, "R6 reset tx_en/done", {tx_en, done}, 0);
        check(tx_valid == 0 && ta_req == 0, "R6 reset tx_valid/ta_req", {tx_valid, ta_req}, 0);
        check(rx_count == 0, "R10 reset rx_count", rx_count, 0);
    endtask

    // R1 R2 R3 R6: three short commands, slot 3 must stay unsent.
    task automatic t_short_list();
        prog_slot(0, 6'h05, 2'd0, 16'h0011, 0);
        prog_slot(1, 6'h15, 2'd1, 16'hC036, 0);
        prog_slot(2, 6'h06, 2'd3, 16'h000A, 0);
        prog_slot(3, 6'h23, 2'd2, 16'hBEEF, 0);
        last_idx = 3'd2; eot_en = 0; ta_en = 0;
        clear_cap();
        add_hdr(6'h05, 2'd0, 16'h0011); add_hdr(6'h15, 2'd1, 16'hC036); add_hdr(6'h06, 2'd3, 16'h000A);
        pulse_start();
        @(negedge clk);
        check(tx_en == 1, "R6 tx_en after start", tx_en, 1);
        wait_done("R1");
        cmp_stream("R1 R2 R3 short list");
        check(cap[4] == 8'h55 && cap[5] == 8'h36 && cap[6] == 8'hC0, "R2 field order",
              {cap[4], cap[5], cap[6]}, 24'h5536C0);
        check(tx_en == 0, "R6 tx_en self-clear", tx_en, 0);
    endtask

    // R4 R5: mixed long/short with zero-length long at the end.
    task automatic load_mixed();
        for (int i = 0; i < 8; i++) ram_write(i, 8'(i * 37 + 3));
        prog_slot(0, 6'h39, 2'd1, 16'd5, 1);
        prog_slot(1, 6'h15, 2'd0, 16'h80B0, 0);
        prog_slot(2, 6'h39, 2'd2, 16'd3, 1);
        prog_slot(3, 6'h29, 2'd3, 16'd0, 1);
        last_idx = 3'd3; eot_en = 0; ta_en = 0;
    endtask

    task automatic build_mixed();
        add_long(6'h39, 2'd1, 5, 0);
        add_hdr(6'h15, 2'd0, 16'h80B0);
        add_long(6'h39, 2'd2, 3, 5);
        add_long(6'h29, 2'd3, 0, 8);
    endtask

    task automatic t_long_list();
        load_mixed(); clear_cap(); build_mixed();
        pulse_start(); wait_done("R4");
        cmp_stream("R4 R5 long payloads");
        check(cap[cap_n-2] == 8'hFF && cap[cap_n-1] == 8'hFF, "R5 empty CRC",
              {cap[cap_n-2], cap[cap_n-1]}, 16'hFFFF);
    endtask

    task automatic t_backpressure();
        load_mixed(); clear_cap(); build_mixed();
        throttle = 1;
        pulse_start(); wait_done("R12");
        throttle = 0;
        cmp_stream("R12 throttled stream");
    endtask

    task automatic t_eot();
        prog_slot(0, 6'h05, 2'd2, 16'h0029, 0);
        last_idx = 0; eot_en = 1; ta_en = 0;
        clear_cap(); add_hdr(6'h05, 2'd2, 16'h0029);
        push(8'h08); push(8'h0F); push(8'h0F); push(8'h01);
        pulse_start(); wait_done("R7");
        cmp_stream("R7 end packet present");
        eot_en = 0; clear_cap(); add_hdr(6'h05, 2'd2, 16'h0029);
        pulse_start(); wait_done("R7");
        cmp_stream("R7 end packet absent");
    endtask

    task automatic t_pause();
        prog_slot(0, 6'h15, 2'd1, 16'h7733, 0);
        last_idx = 0; eot_en = 0; ta_en = 0;
        clear_cap(); add_hdr(6'h15, 2'd1, 16'h7733);
        @(posedge clk); #1; seq_pause = 1;
        pulse_start();
        repeat (20) @(negedge clk);
        check(valid_cycles == 0 && tx_en == 1, "R13 paused no header", valid_cycles, 0);
        @(posedge clk); #1; seq_pause = 0;
        wait_done("R13");
        cmp_stream("R13 after release");
    endtask

    task automatic t_busy_start();
        load_mixed(); clear_cap(); build_mixed();
        pulse_start();
        repeat (6) @(negedge clk);
        pulse_start();
        wait_done("R11");
        repeat (10) @(negedge clk);
        check(tx_en == 0, "R11 no second run", tx_en, 0);
        cmp_stream("R11 single stream");
    endtask

    task automatic t_turnaround();
        logic [7:0] v;
        prog_slot(0, 6'h06, 2'd0, 16'h00DA, 0);
        last_idx = 0; eot_en = 0; ta_en = 1; rx_base = 8'd250;
        clear_cap(); add_hdr(6'h06, 2'd0, 16'h00DA);
        pulse_start();
        for (int t = 0; t < 200 && !ta_seen; t++) @(negedge clk);
        check(ta_seen && cap_at_ta == 4, "R8 request after last byte", cap_at_ta, 4);
        for (int i = 0; i < 10; i++) rx_send(8'(8'h40 + i));
        rx_finish();
        wait_done("R8");
        cmp_stream("R8 read command");
        check(rx_count == 10, "R8 R10 rx_count", rx_count, 10);
        read_ram(250, v); check(v == 8'h40, "R8 first at base", v, 8'h40);
        read_ram(255, v); check(v == 8'h45, "R8 at 255", v, 8'h45);
        read_ram(3, v);   check(v == 8'h49, "R8 wrap to 3", v, 8'h49);
        ta_en = 0;
    endtask

    task automatic t_ta_only();
        ta_only = 1; ta_en = 0; rx_base = 8'd20; clear_cap();
        pulse_start();
        for (int t = 0; t < 50 && !ta_seen; t++) @(negedge clk);
        check(ta_seen && cap_n == 0, "R9 turnaround only", cap_n, 0);
        rx_send(8'h9C); rx_send(8'h3D); rx_finish();
        wait_done("R9");
        check(rx_count == 2 && cap_n == 0, "R9 count and silence", rx_count, 2);
        ta_only = 0;
    endtask

    task automatic t_saturate();
        logic [7:0] v;
        ta_only = 1; rx_base = 8'h10; clear_cap();
        pulse_start();
        for (int t = 0; t < 50 && !ta_seen; t++) @(negedge clk);
        for (int i = 0; i < 260; i++) rx_send(i < 256 ? 8'(i ^ 8'hA5) : 8'h3C);
        @(negedge clk);
        check(rx_count == 256, "R10 saturate at 256", rx_count, 256);
        rx_finish(); wait_done("R10");
        read_ram(8'h10, v); check(v == 8'hA5, "R10 no overwrite", v, 8'hA5);
        read_ram(8'h0F, v); check(v == 8'h5A, "R10 last stored", v, 8'h5A);
        ta_only = 0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_short_list();
        t_long_list();
        t_backpressure();
        t_eot();
        t_pause();
        t_busy_start();
        t_turnaround();
        t_ta_only();
        t_saturate();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule